// File: doc/BRIEF.md
# Profiling Control Register Access Gate

This block decides what happens when software tries to read or write a protected profiling control register. Each attempt is checked against the current privilege level (0 to 3), which of levels 2 and 3 exist, the trap controls that levels 2 and 3 own, and an ownership check that level 3 applies. The result is one of four outcomes: the access goes ahead, it is rejected as an undefined instruction, it traps to level 2, or it traps to level 3. A trapping outcome also carries a fixed exception class.

The inputs are sampled on a one-cycle access strobe. The outcome, a one-cycle valid pulse and the exception class are registered, so they appear on the edge after the strobe. The outcome then holds until the next strobe. Each level has its own order of checks. At level 1, a level-3 "undefined takes priority" rule is checked before either level-2 trap. The read and write fine-grained trap bits are separate inputs, and a direction select picks one of them.

Top module: `prof_access_gate`

## Requirements
- R1: While reset is low, and at the first edge after reset, `result` is 2'b00, `result_vld` is 0 and `trap_ec` is 0.
- R2: An access from level 0 (`cur_lvl` = 0) gives undefined (`result` = 2'b01), whatever the other inputs are.
- R3: An access from level 3 always gives allow (2'b00).
- R4: At levels 1 and 2, when level 3 exists, `undef_first` is 1 and ownership fails, the result is undefined. At level 1 this check comes before both level-2 traps.
- R5: At level 1, a fine-grained trap to level 2 (2'b10) happens when level 2 exists and is enabled, the fine-grained feature is present, level 3 is absent or `l3_fgt_en` is 1, and the trap bit that `is_write` selects is 1. That bit is `fgt_rd_trap` for reads and `fgt_wr_trap` for writes.
- R6: At level 1, when no fine-grained trap happens, `coarse_trap` = 1 with level 2 present and enabled gives trap to level 2.
- R7: At levels 1 and 2, after the earlier checks, a failed ownership check with level 3 present gives undefined if `undef_policy` is 1, and trap to level 3 (2'b11) otherwise. With level 3 absent, ownership is not checked.
- R8: Ownership fails when `own_en` is 0, or when `own_ns` differs from `cur_ns`, or when `realm_present` is 1 and `own_nse` differs from `cur_nse`.
- R9: A level-2 access never gives trap to level 2, whatever the fine-grained and coarse trap bits are.
- R10: `trap_ec` is 6'h18 whenever `result` is a trap (2'b10 or 2'b11), and 0 otherwise.
- R11: Outcome encoding: 00 allow, 01 undefined, 10 trap to level 2, 11 trap to level 3. The inputs are registered when `acc_vld` is high. `result_vld` pulses on the next edge. The outcome holds while `acc_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe; samples the inputs |
| is_write | input | 1 | 1 = write, 0 = read |
| cur_lvl | input | 2 | Current privilege level |
| has_l2 | input | 1 | Level 2 implemented |
| has_l3 | input | 1 | Level 3 implemented |
| l2_en | input | 1 | Level 2 enabled in the current state |
| fgt_present | input | 1 | Fine-grained trap feature present |
| l3_fgt_en | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap bit for writes |
| coarse_trap | input | 1 | Coarse profiling trap to level 2 |
| own_en | input | 1 | Ownership enable |
| own_ns | input | 1 | Ownership security bit |
| cur_ns | input | 1 | Current non-secure state |
| realm_present | input | 1 | Realm feature present |
| own_nse | input | 1 | Extended ownership bit |
| cur_nse | input | 1 | Current extended security state |
| undef_policy | input | 1 | Failed ownership gives undefined instead of a level-3 trap |
| undef_first | input | 1 | Undefined check comes before the level-2 traps |
| result | output | 2 | Registered outcome |
| result_vld | output | 1 | One-cycle pulse after a strobe |
| trap_ec | output | 6 | Exception class; 0x18 on a trap |

## Verification
The vector table pairs cases that differ in one control bit only, so each case shows the effect of that bit alone. Some pairs show that only the read or only the write trap bit counts for a given direction. Others show that the level-3 fine-grained enable only matters when level 3 exists. Each of the three ownership conditions, including the realm bit while the realm feature is off, has its own case. Conflict cases, in which an ownership failure meets a pending level-2 trap, show the order of checks: the undefined-first rule wins over the level-2 traps, and the level-2 traps win over the later ownership outcome. Directed steps check that the outcome holds between strobes and that reset clears it.

// File: rtl/prof_access_gate.sv
module prof_access_gate #(
  parameter int EC_W = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_vld,
  input  logic            is_write,
  input  logic [1:0]      cur_lvl,
  input  logic            has_l2,
  input  logic            has_l3,
  input  logic            l2_en,
  input  logic            fgt_present,
  input  logic            l3_fgt_en,
  input  logic            fgt_rd_trap,
  input  logic            fgt_wr_trap,
  input  logic            coarse_trap,
  input  logic            own_en,
  input  logic            own_ns,
  input  logic            cur_ns,
  input  logic            realm_present,
  input  logic            own_nse,
  input  logic            cur_nse,
  input  logic            undef_policy,
  input  logic            undef_first,
  output logic [1:0]      result,
  output logic            result_vld,
  output logic [EC_W-1:0] trap_ec
);

  localparam logic [1:0] RES_ALLOW = 2'b00;
  localparam logic [1:0] RES_UNDEF = 2'b01;
  localparam logic [1:0] RES_TRAP2 = 2'b10;
  localparam logic [1:0] RES_TRAP3 = 2'b11;

  logic own_fail, l2_live, fgt_hit, early_undef, late_fail;
  logic [1:0] nxt;

  assign own_fail    = !own_en || (own_ns != cur_ns) ||
                       (realm_present && (own_nse != cur_nse));
  assign l2_live     = has_l2 && l2_en;
  assign fgt_hit     = l2_live && fgt_present && (!has_l3 || l3_fgt_en) &&
                       (is_write ? fgt_wr_trap : fgt_rd_trap);
  assign early_undef = has_l3 && undef_first && own_fail;
  assign late_fail   = has_l3 && own_fail;

  always_comb begin
    nxt = RES_ALLOW;
    unique case (cur_lvl)
      2'd0: nxt = RES_UNDEF;
      2'd1: begin
        if (early_undef)               nxt = RES_UNDEF;
        else if (fgt_hit)              nxt = RES_TRAP2;
        else if (l2_live && coarse_trap) nxt = RES_TRAP2;
        else if (late_fail)            nxt = undef_policy ? RES_UNDEF : RES_TRAP3;
        else                           nxt = RES_ALLOW;
      end
      2'd2: begin
        if (early_undef)               nxt = RES_UNDEF;
        else if (late_fail)            nxt = undef_policy ? RES_UNDEF : RES_TRAP3;
        else                           nxt = RES_ALLOW;
      end
      default: nxt = RES_ALLOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= RES_ALLOW;
      result_vld <= 1'b0;
      trap_ec    <= '0;
    end else begin
      result_vld <= acc_vld;
      if (acc_vld) begin
        result  <= nxt;
        trap_ec <= nxt[1] ? TRAP_EC : '0;
      end
    end
  end

endmodule

// File: rtl/prof_access_gate_chk.sv
module prof_access_gate_chk #(
  parameter int EC_W = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_vld,
  input logic [1:0]      cur_lvl,
  input logic [1:0]      result,
  input logic            result_vld,
  input logic [EC_W-1:0] trap_ec
);

  // R11
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> result_vld);

  // R11
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !result_vld);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(result));

  // R2
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_lvl == 2'd0) |=> result == 2'b01);

  // R3
  lvl3_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_lvl == 2'd3) |=> result == 2'b00);

  // R9
  lvl2_no_l2trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_lvl == 2'd2) |=> result != 2'b10);

  // R10
  ec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ec == (result[1] ? TRAP_EC : '0));

endmodule

bind prof_access_gate prof_access_gate_chk #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .cur_lvl(cur_lvl),
  .result(result), .result_vld(result_vld), .trap_ec(trap_ec)
);

// File: tb/prof_access_gate_test.sv
module prof_access_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic clk = 1'b0, rst_n = 1'b0, acc_vld = 1'b0, is_write = 1'b0;
  logic [1:0] cur_lvl = 2'd0;
  logic has_l2 = 0, has_l3 = 0, l2_en = 0, fgt_present = 0, l3_fgt_en = 0;
  logic fgt_rd_trap = 0, fgt_wr_trap = 0, coarse_trap = 0;
  logic own_en = 0, own_ns = 0, cur_ns = 0, realm_present = 0, own_nse = 0, cur_nse = 0;
  logic undef_policy = 0, undef_first = 0;
  logic [1:0] result;
  logic result_vld;
  logic [5:0] trap_ec;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prof_access_gate uut (.*);

  // Field groups: lvl(2)_wr(1)_{h2 h3 l2en}_{fgtp l3fe frd fwr coarse}_
  //               {oen ons cns realm onse cnse}_{upol ufirst}_expected(2)
  localparam logic [20:0] VEC [NV] = '{
    21'b00_0_111_11111_111000_00_01, // R2 level 0
    21'b11_0_111_11111_000000_11_00, // R3 level 3 despite owner fail
    21'b01_0_111_00000_111000_00_00, // level 1 clean
    21'b01_0_111_11100_111000_00_10, // R5 read fgt
    21'b01_1_111_11100_111000_00_00, // R5 write ignores read bit
    21'b01_1_111_11010_111000_00_10, // R5 write fgt
    21'b01_0_111_10100_111000_00_00, // R5 l3 present, fgt enable off
    21'b01_0_101_10100_111000_00_10, // R5 l3 absent
    21'b01_0_111_01100_111000_00_00, // R5 feature absent
    21'b01_0_111_00001_111000_00_10, // R6 coarse
    21'b01_0_110_00001_111000_00_00, // R6 l2 not enabled
    21'b01_0_111_00001_011000_01_01, // R4 undef-first beats coarse
    21'b01_0_111_00001_011000_10_10, // R6 coarse beats late owner check
    21'b01_0_111_00000_011000_00_11, // R7 trap3
    21'b01_0_111_00000_011000_10_01, // R7 undef policy
    21'b01_0_101_00000_011000_00_00, // R7 no l3
    21'b01_0_111_00000_101000_00_11, // R8 security mismatch
    21'b01_0_111_00000_111110_00_11, // R8 realm mismatch
    21'b01_0_111_00000_111111_00_00, // R8 realm match
    21'b01_0_111_00000_111010_00_00, // R8 realm absent
    21'b10_0_111_11111_111000_00_00, // R9 level 2 skips l2 traps
    21'b10_0_111_11111_011000_01_01, // R4 level 2 undef-first
    21'b10_0_111_11111_011000_00_11, // R7 level 2 trap3
    21'b10_0_101_11111_011000_00_00, // R7 level 2 no l3
    21'b01_0_101_00001_011000_11_10, // R4 needs l3
    21'b01_0_011_11111_111000_00_00  // R5 R6 l2 absent
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [20:0] v);
    @(negedge clk);
    {cur_lvl, is_write, has_l2, has_l3, l2_en, fgt_present, l3_fgt_en,
     fgt_rd_trap, fgt_wr_trap, coarse_trap, own_en, own_ns, cur_ns,
     realm_present, own_nse, cur_nse, undef_policy, undef_first} = v[20:2];
    acc_vld = 1'b1;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 result", result, 2'b00);
    check("R1 vld", result_vld, 1'b0);
    check("R1 ec", trap_ec, 6'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld after reset", result_vld, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R11 vld vec%0d", i), result_vld, 1'b1);
      check($sformatf("R2-R9 result vec%0d", i), result, VEC[i][1:0]);
      check($sformatf("R10 ec vec%0d", i), trap_ec, VEC[i][1] ? 6'h18 : 6'h0);
    end

    // R11 hold: trap3 captured, then inputs change without a strobe
    apply(21'b01_0_111_00000_011000_00_11);
    cur_lvl = 2'd0;
    repeat (3) @(negedge clk);
    check("R11 hold result", result, 2'b11);
    check("R11 vld low", result_vld, 1'b0);
    check("R10 ec held", trap_ec, 6'h18);

    // R1 reset clears a trap outcome
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset result", result, 2'b00);
    check("R1 reset ec", trap_ec, 6'h0);
    rst_n = 1'b1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule